// File: doc/BRIEF.md
# Dataflow Operand Matching Store

This block is the operand-pairing stage at the input of a dataflow processing element. Every incoming token names a context slot, an instruction offset, an input port (left or right) and a data word. Instructions are laid out so that the two-input instructions sit at the lowest offsets, from 0 up to NUM_DYADIC-1. Single-input instructions sit at NUM_DYADIC and above. A token for a single-input instruction is ready at once and goes straight to the output. A token for a two-input instruction is parked until its partner arrives. The matched pair is then released with the left operand and the right operand in fixed positions.

Parked operands are kept in a table indexed by context slot and by the offset itself, so no address translation is needed. Each context slot has its own row, which lets several activations of the same code run at once without mixing their operands. A slot-release input empties a whole row in one cycle so that the slot can be handed to a new activation. A second token arriving on the port that is already parked is a program error. It is flagged and dropped.

There is no backpressure. Every result appears on the registered outputs exactly one cycle after the token that caused it.

Top module: `operand_match_store`

## Requirements
- R1: While reset is asserted and in the first cycle after it, fire_valid_o and err_o are 0, and every table entry is empty.
- R2: A token with tok_off_i >= NUM_DYADIC is single-input. One cycle later it produces fire_valid_o=1, fire_pair_o=0, fire_left_o=data, fire_right_o=0, with its ctx and offset echoed. It never reads or changes the table, so an operand parked at a lower offset is unaffected.
- R3: A two-input token (tok_off_i < NUM_DYADIC) that finds its entry empty is parked. The next cycle shows fire_valid_o=0 and err_o=0.
- R4: A two-input token that finds its entry holding the opposite port fires one cycle later with fire_pair_o=1. fire_left_o carries the port-0 (left) value and fire_right_o carries the port-1 (right) value, whichever arrived first. The entry becomes empty again.
- R5: Entries with the same offset in different context slots never pair with each other.
- R6: Entries with different offsets in the same context slot never pair with each other.
- R7: A two-input token that finds its entry holding the same port raises err_o for one cycle with fire_valid_o=0. The new value is discarded and the parked value is kept.
- R8: free_valid_i with free_ctx_i=c empties every entry of slot c one cycle later. Other slots keep their parked operands.
- R9: When a release and a token name the same slot in the same cycle, the token sees the emptied slot and is parked as a first operand.
- R10: fire_valid_o and err_o are single-cycle pulses, are never both 1, and are 0 in a cycle that follows no token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_valid_i | input | 1 | Token present this cycle |
| tok_ctx_i | input | CTX_W | Context slot of the token |
| tok_off_i | input | OFF_W | Instruction offset of the token |
| tok_port_i | input | 1 | Input port, 0 = left, 1 = right |
| tok_data_i | input | DATA_W | Token value |
| free_valid_i | input | 1 | Release a context slot this cycle |
| free_ctx_i | input | CTX_W | Slot to release |
| fire_valid_o | output | 1 | Instruction ready to execute |
| fire_pair_o | output | 1 | 1 for a matched pair, 0 for a single-input token |
| fire_ctx_o | output | CTX_W | Context slot of the firing instruction |
| fire_off_o | output | OFF_W | Offset of the firing instruction |
| fire_left_o | output | DATA_W | Left operand, or the sole operand |
| fire_right_o | output | DATA_W | Right operand, 0 for single-input |
| err_o | output | 1 | Same-port duplicate was dropped |

## Verification
The hardest case to reach from the ports is a slot release that lands in the same cycle as a token for that slot, while an operand is already parked there. The bench parks a left operand first. It then drives the release and the matching right token together in one cycle and expects no fire. A later left token must pair with the right value that arrived during the release, not with the operand that was discarded. A similar check covers a duplicate-port token: the pair that follows must carry the original parked value.

// File: rtl/mstore_pkg.sv
package mstore_pkg;
  typedef enum logic {
    PORT_L = 1'b0,
    PORT_R = 1'b1
  } port_e;
endpackage

// File: rtl/mstore_classify.sv
module mstore_classify #(
  parameter int OFF_W      = 7,
  parameter int NUM_DYADIC = 16,
  localparam int IDX_W     = (NUM_DYADIC > 1) ? $clog2(NUM_DYADIC) : 1
) (
  input  logic [OFF_W-1:0] off_i,
  output logic             dyadic_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [OFF_W-1:0] DYAD_LIM = OFF_W'(NUM_DYADIC);

  assign dyadic_o = (off_i < DYAD_LIM);
  assign idx_o    = off_i[IDX_W-1:0];
endmodule

// File: rtl/mstore_bank.sv
module mstore_bank #(
  parameter int NUM_CTX    = 16,
  parameter int NUM_DYADIC = 16,
  parameter int DATA_W     = 16,
  localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int IDX_W     = (NUM_DYADIC > 1) ? $clog2(NUM_DYADIC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              wr_port_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              free_i,
  input  logic [CTX_W-1:0]  free_ctx_i,
  output logic              present_o,
  output logic              port_o,
  output logic [DATA_W-1:0] data_o
);
  logic [NUM_CTX-1:0][NUM_DYADIC-1:0] pres;
  logic [DATA_W-1:0] val_q  [NUM_CTX][NUM_DYADIC];
  logic              port_q [NUM_CTX][NUM_DYADIC];

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_row
    logic [NUM_DYADIC-1:0] row_q;
    logic                  row_free;
    logic                  row_sel;

    assign row_free = free_i && (free_ctx_i == CTX_W'(c));
    assign row_sel  = (ctx_i == CTX_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
      end else begin
        if (row_free) row_q <= '0;
        // token in the same cycle applies after the release
        if (row_sel && set_i) row_q[idx_i] <= 1'b1;
        if (row_sel && clr_i) row_q[idx_i] <= 1'b0;
      end
    end

    assign pres[c] = row_q;
  end

  always_ff @(posedge clk_i) begin
    if (set_i) begin
      val_q[ctx_i][idx_i]  <= wr_data_i;
      port_q[ctx_i][idx_i] <= wr_port_i;
    end
  end

  assign present_o = pres[ctx_i][idx_i] && !(free_i && (free_ctx_i == ctx_i));
  assign port_o    = port_q[ctx_i][idx_i];
  assign data_o    = val_q[ctx_i][idx_i];
endmodule

// File: rtl/mstore_fire.sv
module mstore_fire #(
  parameter int CTX_W  = 4,
  parameter int OFF_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              pair_i,
  input  logic              err_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              fire_valid_o,
  output logic              fire_pair_o,
  output logic [CTX_W-1:0]  fire_ctx_o,
  output logic [OFF_W-1:0]  fire_off_o,
  output logic [DATA_W-1:0] fire_left_o,
  output logic [DATA_W-1:0] fire_right_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_valid_o <= 1'b0;
      fire_pair_o  <= 1'b0;
      fire_ctx_o   <= '0;
      fire_off_o   <= '0;
      fire_left_o  <= '0;
      fire_right_o <= '0;
      err_o        <= 1'b0;
    end else begin
      fire_valid_o <= fire_i;
      err_o        <= err_i;
      if (fire_i) begin
        fire_pair_o  <= pair_i;
        fire_ctx_o   <= ctx_i;
        fire_off_o   <= off_i;
        fire_left_o  <= left_i;
        fire_right_o <= right_i;
      end
    end
  end
endmodule

// File: rtl/operand_match_store.sv
module operand_match_store #(
  parameter int NUM_CTX    = 16,
  parameter int NUM_DYADIC = 16,
  parameter int OFF_W      = 7,
  parameter int DATA_W     = 16,
  localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_valid_i,
  input  logic [CTX_W-1:0]  tok_ctx_i,
  input  logic [OFF_W-1:0]  tok_off_i,
  input  logic              tok_port_i,
  input  logic [DATA_W-1:0] tok_data_i,
  input  logic              free_valid_i,
  input  logic [CTX_W-1:0]  free_ctx_i,
  output logic              fire_valid_o,
  output logic              fire_pair_o,
  output logic [CTX_W-1:0]  fire_ctx_o,
  output logic [OFF_W-1:0]  fire_off_o,
  output logic [DATA_W-1:0] fire_left_o,
  output logic [DATA_W-1:0] fire_right_o,
  output logic              err_o
);
  import mstore_pkg::*;

  localparam int IDX_W = (NUM_DYADIC > 1) ? $clog2(NUM_DYADIC) : 1;

  logic              is_dyad;
  logic [IDX_W-1:0]  idx;
  logic              hit, hit_port;
  logic [DATA_W-1:0] hit_data;
  logic              dyad_tok, do_park, do_match, do_drop, do_mono;
  logic              do_fire;
  logic [DATA_W-1:0] left_val, right_val;
  port_e             tok_port;

  assign tok_port = port_e'(tok_port_i);

  mstore_classify #(
    .OFF_W      (OFF_W),
    .NUM_DYADIC (NUM_DYADIC)
  ) u_classify (
    .off_i    (tok_off_i),
    .dyadic_o (is_dyad),
    .idx_o    (idx)
  );

  assign dyad_tok = tok_valid_i && is_dyad;
  assign do_mono  = tok_valid_i && !is_dyad;
  assign do_park  = dyad_tok && !hit;
  assign do_match = dyad_tok && hit && (hit_port != tok_port_i);
  assign do_drop  = dyad_tok && hit && (hit_port == tok_port_i);
  assign do_fire  = do_mono || do_match;

  mstore_bank #(
    .NUM_CTX    (NUM_CTX),
    .NUM_DYADIC (NUM_DYADIC),
    .DATA_W     (DATA_W)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctx_i      (tok_ctx_i),
    .idx_i      (idx),
    .set_i      (do_park),
    .clr_i      (do_match),
    .wr_port_i  (tok_port_i),
    .wr_data_i  (tok_data_i),
    .free_i     (free_valid_i),
    .free_ctx_i (free_ctx_i),
    .present_o  (hit),
    .port_o     (hit_port),
    .data_o     (hit_data)
  );

  always_comb begin
    left_val  = tok_data_i;
    right_val = '0;
    if (do_match) begin
      if (tok_port == PORT_R) begin
        left_val  = hit_data;
        right_val = tok_data_i;
      end else begin
        left_val  = tok_data_i;
        right_val = hit_data;
      end
    end
  end

  mstore_fire #(
    .CTX_W  (CTX_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
  ) u_fire (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (do_fire),
    .pair_i       (do_match),
    .err_i        (do_drop),
    .ctx_i        (tok_ctx_i),
    .off_i        (tok_off_i),
    .left_i       (left_val),
    .right_i      (right_val),
    .fire_valid_o (fire_valid_o),
    .fire_pair_o  (fire_pair_o),
    .fire_ctx_o   (fire_ctx_o),
    .fire_off_o   (fire_off_o),
    .fire_left_o  (fire_left_o),
    .fire_right_o (fire_right_o),
    .err_o        (err_o)
  );
endmodule

// File: rtl/operand_match_store_chk.sv
module operand_match_store_chk #(
  parameter int NUM_CTX    = 16,
  parameter int NUM_DYADIC = 16,
  parameter int OFF_W      = 7,
  parameter int DATA_W     = 16,
  localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tok_valid_i,
  input logic [CTX_W-1:0]  tok_ctx_i,
  input logic [OFF_W-1:0]  tok_off_i,
  input logic              tok_port_i,
  input logic [DATA_W-1:0] tok_data_i,
  input logic              free_valid_i,
  input logic [CTX_W-1:0]  free_ctx_i,
  input logic              fire_valid_o,
  input logic              fire_pair_o,
  input logic [CTX_W-1:0]  fire_ctx_o,
  input logic [OFF_W-1:0]  fire_off_o,
  input logic [DATA_W-1:0] fire_left_o,
  input logic [DATA_W-1:0] fire_right_o,
  input logic              err_o
);
  localparam logic [OFF_W-1:0] DYAD_LIM = OFF_W'(NUM_DYADIC);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!fire_valid_o && !err_o);
    end
  end

  // R2
  mono_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && tok_off_i >= DYAD_LIM) |=>
      (fire_valid_o && !fire_pair_o && !err_o &&
       fire_left_o == $past(tok_data_i) && fire_right_o == '0 &&
       fire_ctx_o == $past(tok_ctx_i) && fire_off_o == $past(tok_off_i)));

  // R4
  pair_is_dyadic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_valid_o && fire_pair_o) |-> (fire_off_o < DYAD_LIM));

  // R10
  fire_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire_valid_o && err_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_valid_i |=> (!fire_valid_o && !err_o));

  // R7
  err_from_dyadic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && tok_off_i >= DYAD_LIM) |=> !err_o);
endmodule

bind operand_match_store operand_match_store_chk #(
  .NUM_CTX    (NUM_CTX),
  .NUM_DYADIC (NUM_DYADIC),
  .OFF_W      (OFF_W),
  .DATA_W     (DATA_W)
) u_chk (.*);

// File: tb/operand_match_store_bench.sv
module operand_match_store_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCTX  = 16;
  localparam int ND    = 16;
  localparam int OFFW  = 7;
  localparam int DW    = 16;
  localparam int CW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tok_valid = 1'b0;
  logic [CW-1:0] tok_ctx = '0;
  logic [OFFW-1:0] tok_off = '0;
  logic          tok_port = 1'b0;
  logic [DW-1:0] tok_data = '0;
  logic          free_valid = 1'b0;
  logic [CW-1:0] free_ctx = '0;
  logic          f_valid, f_pair, f_err;
  logic [CW-1:0] f_ctx;
  logic [OFFW-1:0] f_off;
  logic [DW-1:0] f_left, f_right;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_match_store #(
    .NUM_CTX(NCTX), .NUM_DYADIC(ND), .OFF_W(OFFW), .DATA_W(DW)
  ) u_operand_match_store (
    .clk_i(clk), .rst_ni(rst_n),
    .tok_valid_i(tok_valid), .tok_ctx_i(tok_ctx), .tok_off_i(tok_off),
    .tok_port_i(tok_port), .tok_data_i(tok_data),
    .free_valid_i(free_valid), .free_ctx_i(free_ctx),
    .fire_valid_o(f_valid), .fire_pair_o(f_pair), .fire_ctx_o(f_ctx),
    .fire_off_o(f_off), .fire_left_o(f_left), .fire_right_o(f_right),
    .err_o(f_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one cycle at negedge; results visible at the following negedge
  task automatic step(input bit tv, input int ctx, input int off, input bit port,
                      input int data, input bit fv, input int fctx);
    tok_valid  = tv;
    tok_ctx    = CW'(ctx);
    tok_off    = OFFW'(off);
    tok_port   = port;
    tok_data   = DW'(data);
    free_valid = fv;
    free_ctx   = CW'(fctx);
    @(negedge clk);
    tok_valid  = 1'b0;
    free_valid = 1'b0;
  endtask

  task automatic send(input int ctx, input int off, input bit port, input int data);
    step(1'b1, ctx, off, port, data, 1'b0, 0);
  endtask

  task automatic exp_none(input string req);
    chk(req, "fire_valid", int'(f_valid), 0);
    chk(req, "err", int'(f_err), 0);
  endtask

  task automatic exp_pair(input string req, input int ctx, input int off, input int l, input int r);
    chk(req, "fire_valid", int'(f_valid), 1);
    chk(req, "fire_pair", int'(f_pair), 1);
    chk(req, "err", int'(f_err), 0);
    chk(req, "ctx", int'(f_ctx), ctx);
    chk(req, "off", int'(f_off), off);
    chk(req, "left", int'(f_left), l);
    chk(req, "right", int'(f_right), r);
  endtask

  task automatic t_reset();
    exp_none("R1");
    step(1'b0, 0, 0, 1'b0, 0, 1'b0, 0);
    exp_none("R1");
    // an empty table: first right token on slot 0 only parks
    send(0, 0, 1'b1, 16'h0abc);
    exp_none("R1");
    send(0, 0, 1'b0, 16'h0123);
    exp_pair("R1", 0, 0, 16'h0123, 16'h0abc);
  endtask

  task automatic t_monadic();
    send(3, 16, 1'b0, 16'h1234);
    chk("R2", "fire_valid", int'(f_valid), 1);
    chk("R2", "fire_pair", int'(f_pair), 0);
    chk("R2", "left", int'(f_left), 16'h1234);
    chk("R2", "right", int'(f_right), 0);
    chk("R2", "off", int'(f_off), 16);
    chk("R2", "ctx", int'(f_ctx), 3);
    send(10, 0, 1'b0, 16'h0001);
    exp_none("R3");
    send(10, 16, 1'b1, 16'h0999);
    chk("R2", "alias fire_pair", int'(f_pair), 0);
    chk("R2", "alias left", int'(f_left), 16'h0999);
    send(10, 127, 1'b0, 16'hffff);
    chk("R2", "top off left", int'(f_left), 16'hffff);
    send(10, 0, 1'b1, 16'h0002);
    exp_pair("R2", 10, 0, 1, 2);
  endtask

  task automatic t_pair_orders();
    send(1, 0, 1'b0, 16'h1111);
    exp_none("R3");
    send(1, 0, 1'b1, 16'h2222);
    exp_pair("R4", 1, 0, 16'h1111, 16'h2222);
    step(1'b0, 0, 0, 1'b0, 0, 1'b0, 0);
    exp_none("R10");
    send(2, 15, 1'b1, 16'hbbbb);
    exp_none("R3");
    send(2, 15, 1'b0, 16'haaaa);
    exp_pair("R4", 2, 15, 16'haaaa, 16'hbbbb);
    send(2, 15, 1'b0, 16'h0c0c);
    exp_none("R4");
    send(2, 15, 1'b1, 16'h0d0d);
    exp_pair("R4", 2, 15, 16'h0c0c, 16'h0d0d);
  endtask

  task automatic t_isolation();
    send(4, 5, 1'b0, 1);
    send(5, 5, 1'b1, 2);
    exp_none("R5");
    send(4, 6, 1'b1, 3);
    exp_none("R6");
    send(4, 5, 1'b1, 4);
    exp_pair("R5", 4, 5, 1, 4);
    send(5, 5, 1'b0, 9);
    exp_pair("R5", 5, 5, 9, 2);
    send(4, 6, 1'b0, 7);
    exp_pair("R6", 4, 6, 7, 3);
  endtask

  task automatic t_collide();
    send(6, 3, 1'b0, 16'h0010);
    send(6, 3, 1'b0, 16'h0020);
    chk("R7", "err", int'(f_err), 1);
    chk("R7", "fire_valid", int'(f_valid), 0);
    step(1'b0, 0, 0, 1'b0, 0, 1'b0, 0);
    chk("R10", "err pulse", int'(f_err), 0);
    send(6, 3, 1'b1, 16'h0030);
    exp_pair("R7", 6, 3, 16'h0010, 16'h0030);
  endtask

  task automatic t_free();
    send(7, 1, 1'b0, 5);
    send(8, 1, 1'b0, 6);
    step(1'b0, 0, 0, 1'b0, 0, 1'b1, 7);
    exp_none("R8");
    send(7, 1, 1'b1, 7);
    exp_none("R8");
    send(8, 1, 1'b1, 8);
    exp_pair("R8", 8, 1, 6, 8);
    send(7, 1, 1'b0, 9);
    exp_pair("R8", 7, 1, 9, 7);
  endtask

  task automatic t_free_same_cycle();
    send(9, 2, 1'b0, 16'h0055);
    step(1'b1, 9, 2, 1'b1, 16'h0066, 1'b1, 9);
    exp_none("R9");
    send(9, 2, 1'b0, 16'h0077);
    exp_pair("R9", 9, 2, 16'h0077, 16'h0066);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_in();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_monadic();
    t_pair_orders();
    t_isolation();
    t_collide();
    t_free();
    t_free_same_cycle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic t_reset_in();
    chk("R1", "fire_valid in reset", int'(f_valid), 0);
    chk("R1", "err in reset", int'(f_err), 0);
  endtask
endmodule